// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Pipeline Stage

This block is one stage of a bit-wide dual-rail pipeline. It takes a token from an upstream sender and passes it to a downstream receiver. Each side uses a four-phase, return-to-zero handshake. A token is one high rail out of a false/true pair, and both rails low means the channel is empty. The stage returns an enable to the sender and follows an enable from the receiver.

The stage is built as clocked logic that samples the handshake wires on each rising edge. Every output comes from a register. A parameter selects one of two reset states:

- **Empty variant.** The stage comes up empty. In each cycle it first raises an output rail and then drops the sender's enable. It returns the output to neutral only once the receiver has released its enable and the input is neutral. It then re-arms the sender.
- **Token variant.** The stage comes up already holding a false token, part-way through a cycle. Its return phase runs two branches side by side: clearing the output and re-arming the sender.

If both input rails are ever seen high at once, the stage raises a flag and freezes for that cycle.

Top module: `dr_half_buffer`

## Requirements
- R1: The output rails are never both high. A token is one high rail (false rail = bit value 0, true rail = bit value 1), and both low means empty.
- R2: In the empty variant, reset gives both outputs low and the sender enable high. The stage does not pass any token until it has seen the receiver enable high and both input rails low at the same time.
- R3: An output rail goes high one cycle after the stage, while waiting for data, samples the receiver enable high together with the matching input rail. With the receiver enable low, no output rail goes high.
- R4: The sender enable falls one cycle after an output rail has gone high. It falls only while an output rail is high.
- R5: In the empty variant, the output returns to neutral one cycle after the stage samples the receiver enable low and both input rails low. It stays put while the input is still non-neutral. The sender enable rises one cycle after that.
- R6: In the token variant, reset gives false output rail high, true output rail low and sender enable high.
- R7: In the token variant, the output clears one cycle after the receiver enable is sampled low, even while the input is still high. The sender enable rises one cycle after the input is sampled neutral. No new token is accepted before both have happened. After reset the false token is held until the receiver enable falls.
- R8: When both input rails are sampled high in a cycle, the clash flag is high in the next cycle. No output, enable or internal state changes in that cycle.
- R9: Under random sender and receiver delays, the output bit stream equals the input bit stream. In the token variant one leading 0 comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_f_i | input | 1 | Input false rail |
| src_t_i | input | 1 | Input true rail |
| src_en_o | output | 1 | Enable back to the sender (high = ready for data) |
| dst_f_o | output | 1 | Output false rail |
| dst_t_o | output | 1 | Output true rail |
| dst_en_i | input | 1 | Enable from the receiver (high = ready for data) |
| clash_o | output | 1 | High for one cycle after both input rails were sampled high |

## Verification
Every move the stage makes is due exactly one cycle after the edge that samples its trigger. Examples are an output rail rising after the enable and data are seen, and the output clearing after the receiver releases. The sender enable moves a further cycle after the output has changed, and the clash flag follows its cause by one cycle. The directed checks drive inputs on the falling edge and read each result on the next falling edge. Each delay is counted one register at a time, and a wait state is confirmed by reading an unchanged output at that same point. In the random runs the scoreboard pops a value only when a rail is seen high, so those checks depend on handshake order, not on cycle counts.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Control phases of the stage
  typedef enum logic [2:0] {
    ST_START = 3'd0,  // empty reset: wait for ready receiver and neutral input
    ST_WAIT  = 3'd1,  // wait for a data rail
    ST_ACK   = 3'd2,  // output raised, drop sender enable next
    ST_NEUT  = 3'd3,  // sequential return: wait release and neutral input
    ST_REARM = 3'd4,  // raise sender enable again
    ST_PAR   = 3'd5   // parallel return: two branches
  } hb_state_e;

  typedef struct packed {
    logic f;
    logic t;
  } dr_bit_t;

endpackage

// File: rtl/hb_rail_detect.sv
module hb_rail_detect
  import hb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dr_bit_t rail_i,
  output logic    neutral_o,
  output logic    clash_o,
  output logic    clash_q_o
);

  logic clash_d;

  always_comb begin
    neutral_o = ~rail_i.f & ~rail_i.t;
    clash_o   = rail_i.f & rail_i.t;
    clash_d   = clash_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clash_q_o <= 1'b0;
    else        clash_q_o <= clash_d;
  end

  AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_i.f && rail_i.t) |=> clash_q_o) else $error("clash not flagged"); // R8

endmodule

// File: rtl/hb_out_reg.sv
module hb_out_reg
  import hb_pkg::*;
#(
  parameter bit TOKEN_INIT = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    set_f_i,
  input  logic    set_t_i,
  input  logic    clr_i,
  output dr_bit_t out_o
);

  localparam dr_bit_t RST_VAL = '{f: TOKEN_INIT, t: 1'b0};

  dr_bit_t out_d;
  logic    out_ce;

  always_comb begin
    out_ce = set_f_i | set_t_i | clr_i;
    out_d  = out_o;
    if (clr_i) begin
      out_d = '{f: 1'b0, t: 1'b0};
    end else begin
      if (set_f_i) out_d.f = 1'b1;
      if (set_t_i) out_d.t = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_o <= RST_VAL;
    else if (out_ce) out_o <= out_d;
  end

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_o.f && out_o.t)) else $error("both output rails high"); // R1
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_f_i, set_t_i, clr_i}) <= 1) else $error("conflicting rail commands"); // R1
  AST_SET_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_f_i || set_t_i) |-> (!out_o.f && !out_o.t)) else $error("set while holding"); // R1

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter bit TOKEN_INIT = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  dr_bit_t rail_i,
  input  logic    neutral_i,
  input  logic    hold_i,
  input  logic    dst_en_i,
  output logic    set_f_o,
  output logic    set_t_o,
  output logic    clr_o,
  output logic    src_en_o
);

  localparam hb_state_e ST_RESET  = TOKEN_INIT ? ST_PAR : ST_START;
  localparam hb_state_e ST_RETURN = TOKEN_INIT ? ST_PAR : ST_NEUT;
  localparam logic      BR_IN_RST = TOKEN_INIT;  // input branch already done on token reset

  hb_state_e st_q, st_d;
  logic      en_d;
  logic      br_out_q, br_out_d;  // output-clear branch finished
  logic      br_in_q, br_in_d;    // sender re-arm branch finished
  logic      ctrl_ce;

  // next state
  always_comb begin
    st_d     = st_q;
    en_d     = src_en_o;
    br_out_d = br_out_q;
    br_in_d  = br_in_q;
    set_f_o  = 1'b0;
    set_t_o  = 1'b0;
    clr_o    = 1'b0;
    ctrl_ce  = ~hold_i;
    if (ctrl_ce) begin
      unique case (st_q)
        ST_START: begin
          if (dst_en_i && neutral_i) st_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (dst_en_i && rail_i.f) begin
            set_f_o = 1'b1;
            st_d    = ST_ACK;
          end else if (dst_en_i && rail_i.t) begin
            set_t_o = 1'b1;
            st_d    = ST_ACK;
          end
        end
        ST_ACK: begin
          en_d     = 1'b0;
          br_out_d = 1'b0;
          br_in_d  = 1'b0;
          st_d     = ST_RETURN;
        end
        ST_NEUT: begin
          if (!dst_en_i && neutral_i) begin
            clr_o = 1'b1;
            st_d  = ST_REARM;
          end
        end
        ST_REARM: begin
          en_d = 1'b1;
          st_d = ST_WAIT;
        end
        ST_PAR: begin
          if (!br_out_q && !dst_en_i) begin
            clr_o    = 1'b1;
            br_out_d = 1'b1;
          end
          if (!br_in_q && neutral_i) begin
            en_d    = 1'b1;
            br_in_d = 1'b1;
          end
          if (br_out_d && br_in_d) st_d = ST_WAIT;
        end
        default: st_d = ST_RESET;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RESET;
      src_en_o <= 1'b1;
      br_out_q <= 1'b0;
      br_in_q  <= BR_IN_RST;
    end else if (ctrl_ce) begin
      st_q     <= st_d;
      src_en_o <= en_d;
      br_out_q <= br_out_d;
      br_in_q  <= br_in_d;
    end
  end

  AST_REARM_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_en_o) |-> $past(neutral_i)) else $error("re-armed on busy input"); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(src_en_o) && $stable(st_q))) else $error("moved during clash"); // R8
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (set_f_o || set_t_o) |-> dst_en_i) else $error("output set without receiver enable"); // R3

endmodule

// File: rtl/dr_half_buffer.sv
module dr_half_buffer
  import hb_pkg::*;
#(
  parameter bit TOKEN_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_f_i,
  input  logic src_t_i,
  output logic src_en_o,
  output logic dst_f_o,
  output logic dst_t_o,
  input  logic dst_en_i,
  output logic clash_o
);

  dr_bit_t rail_in;
  dr_bit_t rail_out;
  logic    neutral;
  logic    clash_now;
  logic    set_f, set_t, clr;

  assign rail_in = '{f: src_f_i, t: src_t_i};

  hb_rail_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_i    (rail_in),
    .neutral_o (neutral),
    .clash_o   (clash_now),
    .clash_q_o (clash_o)
  );

  hb_ctrl #(.TOKEN_INIT(TOKEN_INIT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_i    (rail_in),
    .neutral_i (neutral),
    .hold_i    (clash_now),
    .dst_en_i  (dst_en_i),
    .set_f_o   (set_f),
    .set_t_o   (set_t),
    .clr_o     (clr),
    .src_en_o  (src_en_o)
  );

  hb_out_reg #(.TOKEN_INIT(TOKEN_INIT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_f_i (set_f),
    .set_t_i (set_t),
    .clr_i   (clr),
    .out_o   (rail_out)
  );

  assign dst_f_o = rail_out.f;
  assign dst_t_o = rail_out.t;

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dst_f_o) || $rose(dst_t_o)) |-> $past(dst_en_i)) else $error("rail rose without enable"); // R3
  AST_ACK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_en_o) |-> (dst_f_o || dst_t_o)) else $error("ack without data"); // R4
  AST_FALL_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dst_f_o) || $fell(dst_t_o)) |-> !$past(dst_en_i)) else $error("rail cleared early"); // R5
  AST_CLASH_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_f_i && src_t_i) |=> ($stable(dst_f_o) && $stable(dst_t_o))) else $error("outputs moved on clash"); // R8

endmodule

// File: tb/dr_half_buffer_test.sv
module dr_half_buffer_test;

  localparam int NTOK = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] src_f, src_t, dst_en;
  logic [1:0] src_en, dst_f, dst_t, clash;

  int checks = 0;
  int failed = 0;
  int viol_r1 = 0;
  int viol_r3 = 0;
  bit expq0[$];
  bit expq1[$];

  always #10 clk = ~clk;  // 50 MHz

  dr_half_buffer #(.TOKEN_INIT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .src_f_i(src_f[0]), .src_t_i(src_t[0]),
    .src_en_o(src_en[0]), .dst_f_o(dst_f[0]), .dst_t_o(dst_t[0]),
    .dst_en_i(dst_en[0]), .clash_o(clash[0]));

  dr_half_buffer #(.TOKEN_INIT(1'b1)) uut_tok (
    .clk(clk), .rst_n(rst_n), .src_f_i(src_f[1]), .src_t_i(src_t[1]),
    .src_en_o(src_en[1]), .dst_f_o(dst_f[1]), .dst_t_o(dst_t[1]),
    .dst_en_i(dst_en[1]), .clash_o(clash[1]));

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push_exp(int v, bit b);
    if (v == 0) expq0.push_back(b);
    else        expq1.push_back(b);
  endtask

  // driver: random bit stream with random delays
  task automatic sender(int v, int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = 1'($urandom_range(0, 1));
      repeat ($urandom_range(0, 3)) step();
      while (src_en[v] !== 1'b1) step();
      push_exp(v, b);
      if (b) src_t[v] = 1'b1;
      else   src_f[v] = 1'b1;
      step();
      while (src_en[v] !== 1'b0) step();
      repeat ($urandom_range(0, 3)) step();
      src_f[v] = 1'b0;
      src_t[v] = 1'b0;
      step();
    end
  endtask

  // monitor/receiver: pops and compares on each token
  task automatic receiver(int v, int n);
    for (int k = 0; k < n; k++) begin
      bit exp;
      int got;
      while (!(dst_f[v] || dst_t[v])) step();
      got = int'(dst_t[v]);
      if (v == 0 && expq0.size() > 0)      exp = expq0.pop_front();
      else if (v == 1 && expq1.size() > 0) exp = expq1.pop_front();
      else begin
        exp = ~got[0];
        $display("FAIL R9 token with empty queue on channel %0d: actual=%0d expected=none", v, got);
      end
      check_eq("R9", $sformatf("stream bit ch%0d #%0d", v, k), got, int'(exp));
      repeat ($urandom_range(0, 3)) step();
      dst_en[v] = 1'b0;
      step();
      while (dst_f[v] || dst_t[v]) step();
      repeat ($urandom_range(0, 3)) step();
      dst_en[v] = 1'b1;
      step();
    end
  endtask

  // ordering monitor
  logic [1:0] prev_f = '0, prev_t = '0, prev_en = '0;
  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      for (int v = 0; v < 2; v++) begin
        if (dst_f[v] && dst_t[v]) viol_r1++;
        if (((dst_f[v] && !prev_f[v]) || (dst_t[v] && !prev_t[v])) && !prev_en[v]) viol_r3++;
      end
    end
    prev_f  = dst_f;
    prev_t  = dst_t;
    prev_en = dst_en;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - failed, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failed++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n  = 1'b0;
    src_f  = '0;
    src_t  = '0;
    dst_en = 2'b11;
    repeat (3) step();
    check_eq("R2", "reset dst_f", int'(dst_f[0]), 0);
    check_eq("R2", "reset dst_t", int'(dst_t[0]), 0);
    check_eq("R2", "reset src_en", int'(src_en[0]), 1);
    check_eq("R6", "token reset dst_f", int'(dst_f[1]), 1);
    check_eq("R6", "token reset dst_t", int'(dst_t[1]), 0);
    check_eq("R6", "token reset src_en", int'(src_en[1]), 1);

    rst_n    = 1'b1;
    src_f[0] = 1'b1;       // busy input at start: must not pass
    repeat (3) step();
    check_eq("R2", "no token before neutral seen", int'(dst_f[0]), 0);
    check_eq("R7", "token held until release", int'(dst_f[1]), 1);
    src_f[0] = 1'b0;
    step();
    src_t[0] = 1'b1;
    step();
    check_eq("R3", "true rail raised", int'(dst_t[0]), 1);
    check_eq("R3", "false rail stays low", int'(dst_f[0]), 0);
    check_eq("R4", "enable still high", int'(src_en[0]), 1);
    step();
    check_eq("R4", "enable dropped", int'(src_en[0]), 0);
    dst_en[0] = 1'b0;      // released, input still busy
    step();
    check_eq("R5", "output held while input busy", int'(dst_t[0]), 1);
    src_t[0] = 1'b0;
    step();
    check_eq("R5", "output neutral", int'(dst_t[0]), 0);
    check_eq("R5", "enable low before rearm", int'(src_en[0]), 0);
    step();
    check_eq("R5", "enable re-raised", int'(src_en[0]), 1);
    src_f[0] = 1'b1;       // receiver not ready
    step();
    check_eq("R3", "no rise without receiver enable", int'(dst_f[0]), 0);
    dst_en[0] = 1'b1;
    step();
    check_eq("R3", "false rail raised", int'(dst_f[0]), 1);
    src_t[0] = 1'b1;       // clash while about to acknowledge
    step();
    check_eq("R8", "clash flag", int'(clash[0]), 1);
    check_eq("R8", "enable frozen", int'(src_en[0]), 1);
    check_eq("R8", "dst_f frozen", int'(dst_f[0]), 1);
    check_eq("R8", "dst_t frozen", int'(dst_t[0]), 0);
    src_t[0] = 1'b0;
    step();
    check_eq("R8", "clash flag clears", int'(clash[0]), 0);
    check_eq("R4", "ack resumes after clash", int'(src_en[0]), 0);
    src_f[0]  = 1'b0;
    dst_en[0] = 1'b0;
    repeat (2) step();
    dst_en[0] = 1'b1;
    step();

    expq1.push_back(1'b0);  // leading token of the token variant
    fork
      sender(0, NTOK);
      receiver(0, NTOK);
      sender(1, NTOK);
      receiver(1, NTOK + 1);
    join
    check_eq("R9", "queue 0 drained", expq0.size(), 0);
    check_eq("R9", "queue 1 drained", expq1.size(), 0);
    check_eq("R1", "both rails high events", viol_r1, 0);
    check_eq("R3", "rise without enable events", viol_r3, 0);

    repeat (5) step();
    src_t[1] = 1'b1;
    step();
    check_eq("R7", "token variant accepts", int'(dst_t[1]), 1);
    step();
    check_eq("R4", "token variant ack", int'(src_en[1]), 0);
    dst_en[1] = 1'b0;      // input still busy
    step();
    check_eq("R7", "output cleared with busy input", int'(dst_t[1]), 0);
    check_eq("R7", "enable waits for neutral input", int'(src_en[1]), 0);
    src_t[1] = 1'b0;
    step();
    check_eq("R7", "enable raised after neutral", int'(src_en[1]), 1);
    dst_en[1] = 1'b1;
    repeat (2) step();
    summary();
  end

endmodule